// File: doc/BRIEF.md
# Synchronous serial clock selector

This block handles clock selection and edge strobes for the clocked (synchronous) mode of a serial channel. It runs entirely on the system clock. It has two sources for the shift clock. The first is an internal clock made by halving the baud-generator tick stream. That clock is driven out on the serial clock pin. The second is an external clock that arrives on the same pin and is synchronized before use.

From the selected clock, the block makes one-cycle strobes. One tells the transmit shifter when to launch the next bit. The other tells the receive shifter when to sample. An edge-select input swaps these two roles when the clock comes from outside.

The block also measures the external clock period in system clocks. If that period is too short, it raises a sticky error flag. The limit is tighter when double buffering is enabled.

Top module: `sio_clk_sel`

## Requirements
- R1: After reset, `sclk_out` is 1 and `sclk_oe`, `tx_shift`, `rx_sample` and `clk_err` are 0.
- R2: Internal mode is `mode`=00 with `clk_dir`=0 and `xfer_en`=1. In this mode, a `brg_tick` while `sclk_out` is 1 drives `sclk_out` to 0 and gives exactly one `tx_shift` pulse. A tick while `sclk_out` is 0 drives it to 1 and gives exactly one `rx_sample` pulse. Both happen in the cycle after the tick. In this mode, edges on `sclk_in` produce no strobe.
- R3: While `xfer_en` is 0, `sclk_out` is 1 from the next cycle onward. Ticks do not change it, and neither the forced return to 1 nor any tick produces a strobe.
- R4: `sclk_oe` is 1 exactly when `mode`=00 and `clk_dir`=0.
- R5: In external mode (`mode`=00, `clk_dir`=1) with `edge_sel`=0, a rising edge on `sclk_in` gives exactly one `rx_sample` pulse and a falling edge gives exactly one `tx_shift` pulse. Each pulse is high in the third cycle after the pin change.
- R6: In external mode with `edge_sel`=1, the roles are swapped: a rising edge gives one `tx_shift` pulse and a falling edge gives one `rx_sample` pulse.
- R7: With `mode` other than 00, neither strobe is ever asserted and `sclk_oe` is 0.
- R8: In external mode with `dbuf_en`=1, two consecutive rising edges of `sclk_in` at most 6 system clocks apart set `clk_err`. Edges 7 clocks apart do not.
- R9: In external mode with `dbuf_en`=0, the limit is 8: rising edges 8 clocks apart set `clk_err` and edges 9 apart do not.
- R10: `clk_err` stays set until `err_clr` is asserted, which clears it on the next cycle. A clear takes priority over a new error.
- R11: `tx_shift` and `rx_sample` are never high together, and neither is ever high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Channel mode; 00 selects clocked serial mode |
| clk_dir | input | 1 | 0: internal clock driven out, 1: external clock in |
| edge_sel | input | 1 | External clock edge-role swap |
| xfer_en | input | 1 | Lets the internal clock run |
| brg_tick | input | 1 | Baud-generator tick, one cycle wide |
| sclk_in | input | 1 | Serial clock pin input (asynchronous) |
| dbuf_en | input | 1 | Double buffering on; selects the 6-clock period limit |
| err_clr | input | 1 | Clears the clock error flag |
| sclk_out | output | 1 | Serial clock pin drive |
| sclk_oe | output | 1 | Serial clock pin output enable |
| tx_shift | output | 1 | Transmit launch strobe |
| rx_sample | output | 1 | Receive sample strobe |
| clk_err | output | 1 | Sticky external-clock-too-fast flag |

## Verification
Suppose the synchronizer or the edge history holds a wrong value. The effect appears as a missing, doubled or swapped strobe within three cycles of a pin change. Suppose instead the internal clock register is wrong. Then `sclk_out` and the strobe polarity disagree on the very next tick. A fault in the period counter shows only at the next rising edge: `clk_err` is set one clock early or one clock late at the 6 or 8 boundary. The bench therefore measures periods exactly at and next to each limit.

// File: rtl/sio_clk_sel.sv
module sio_clk_sel #(
  parameter int CNT_W     = 5,
  parameter int MINP_DBUF = 6,
  parameter int MINP_SBUF = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       clk_dir,
  input  logic       edge_sel,
  input  logic       xfer_en,
  input  logic       brg_tick,
  input  logic       sclk_in,
  input  logic       dbuf_en,
  input  logic       err_clr,
  output logic       sclk_out,
  output logic       sclk_oe,
  output logic       tx_shift,
  output logic       rx_sample,
  output logic       clk_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LIM_D   = CNT_W'(MINP_DBUF);
  localparam logic [CNT_W-1:0] LIM_S   = CNT_W'(MINP_SBUF);

  logic io_mode, int_mode, ext_mode, int_run;
  assign io_mode  = (mode == 2'b00);
  assign int_mode = io_mode & ~clk_dir;
  assign ext_mode = io_mode & clk_dir;
  assign int_run  = int_mode & xfer_en;
  assign sclk_oe  = int_mode;

  // internal clock: halved tick stream, idles high
  logic sclk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sclk_q <= 1'b1;
    else if (!int_run)   sclk_q <= 1'b1;
    else if (brg_tick)   sclk_q <= ~sclk_q;
  end
  assign sclk_out = sclk_q;

  logic int_fall, int_rise;
  assign int_fall = int_run & brg_tick &  sclk_q;
  assign int_rise = int_run & brg_tick & ~sclk_q;

  // external clock synchronizer and edge history
  logic s1, s2, s_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s_prev <= 1'b0;
    end else begin
      s1 <= sclk_in; s2 <= s1; s_prev <= s2;
    end
  end

  logic ext_rise, ext_fall;
  assign ext_rise = ext_mode &  s2 & ~s_prev;
  assign ext_fall = ext_mode & ~s2 &  s_prev;

  logic tx_d, rx_d;
  assign tx_d = int_fall | (edge_sel ? ext_rise : ext_fall);
  assign rx_d = int_rise | (edge_sel ? ext_fall : ext_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_shift <= 1'b0; rx_sample <= 1'b0;
    end else begin
      tx_shift <= tx_d; rx_sample <= rx_d;
    end
  end

  // external period measurement between rising edges
  logic [CNT_W-1:0] per_cnt;
  logic             seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0; seen <= 1'b0;
    end else if (!ext_mode) begin
      per_cnt <= '0; seen <= 1'b0;
    end else if (ext_rise) begin
      per_cnt <= CNT_W'(1); seen <= 1'b1;
    end else if (per_cnt != CNT_MAX) begin
      per_cnt <= per_cnt + 1'b1;
    end
  end

  logic too_fast;
  assign too_fast = ext_rise & seen & (per_cnt <= (dbuf_en ? LIM_D : LIM_S));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        clk_err <= 1'b0;
    else if (err_clr)  clk_err <= 1'b0;
    else if (too_fast) clk_err <= 1'b1;
  end

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(tx_shift && rx_sample)); // R11
  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) tx_shift |=> !tx_shift); // R11
  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rx_sample |=> !rx_sample); // R11
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !xfer_en |=> sclk_out); // R3
  AST_QUIET_NON_IO: assert property (@(posedge clk) disable iff (!rst_n) (mode != 2'b00) |=> (!tx_shift && !rx_sample)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (clk_err && !err_clr) |=> clk_err); // R10
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) err_clr |=> !clk_err); // R10

endmodule

// File: tb/sio_clk_sel_bench.sv
module sio_clk_sel_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic clk_dir = 1'b1, edge_sel = 1'b0, xfer_en = 1'b0, brg_tick = 1'b0;
  logic sclk_in = 1'b0, dbuf_en = 1'b1, err_clr = 1'b0;
  logic sclk_out, sclk_oe, tx_shift, rx_sample, clk_err;

  always #2 clk = ~clk;

  sio_clk_sel u_sio_clk_sel (.*);

  int n_chk = 0, n_bad = 0, tx_cnt = 0, rx_cnt = 0, dual_cnt = 0;

  always @(negedge clk) begin
    if (tx_shift) tx_cnt++;
    if (rx_sample) rx_cnt++;
    if (tx_shift && rx_sample) dual_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    brg_tick = 1'b1; @(negedge clk); brg_tick = 1'b0;
  endtask

  task automatic train(input int per, input int n);
    for (int k = 0; k < n; k++) begin
      sclk_in = 1'b1; waitn(2); sclk_in = 1'b0; waitn(per - 2);
    end
  endtask

  // {mode, clk_dir, edge_sel, rise_tx, rise_rx, fall_tx, fall_rx}
  localparam logic [7:0] VEC [5] = '{
    8'b00_1_0_0_1_1_0,
    8'b00_1_1_1_0_0_1,
    8'b01_1_0_0_0_0_0,
    8'b11_1_1_0_0_0_0,
    8'b00_0_0_0_0_0_0
  };

  function automatic string vreq(input int i);
    case (i)
      0: return "R5";
      1: return "R6";
      2, 3: return "R7";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    waitn(3);
    chk("R1 sclk_out", sclk_out, 1); chk("R1 oe", sclk_oe, 0);
    chk("R1 tx", tx_shift, 0); chk("R1 rx", rx_sample, 0); chk("R1 err", clk_err, 0);
    rst_n = 1'b1; waitn(2);

    foreach (VEC[i]) begin
      {mode, clk_dir, edge_sel} = VEC[i][7:4];
      waitn(30); tx_cnt = 0; rx_cnt = 0;
      sclk_in = 1'b1; waitn(6);
      chk({vreq(i), " rise tx"}, tx_cnt, int'(VEC[i][3]));
      chk({vreq(i), " rise rx"}, rx_cnt, int'(VEC[i][2]));
      tx_cnt = 0; rx_cnt = 0;
      sclk_in = 1'b0; waitn(6);
      chk({vreq(i), " fall tx"}, tx_cnt, int'(VEC[i][1]));
      chk({vreq(i), " fall rx"}, rx_cnt, int'(VEC[i][0]));
      chk("R7 R4 oe", sclk_oe, int'(VEC[i][7:5] == 3'b000));
    end

    // R5 latency
    mode = 2'b00; clk_dir = 1'b1; edge_sel = 1'b0; waitn(30);
    sclk_in = 1'b1; waitn(2);
    chk("R5 early", rx_sample, 0);
    waitn(1);
    chk("R5 third cycle", rx_sample, 1);
    sclk_in = 1'b0; waitn(30);

    // internal clock
    clk_dir = 1'b0; xfer_en = 1'b1; waitn(2);
    chk("R4 oe", sclk_oe, 1);
    tx_cnt = 0; rx_cnt = 0;
    tick(); waitn(1);
    chk("R2 fall out", sclk_out, 0); chk("R2 fall tx", tx_cnt, 1); chk("R2 fall rx", rx_cnt, 0);
    waitn(3); tick(); waitn(1);
    chk("R2 rise out", sclk_out, 1); chk("R2 rise tx", tx_cnt, 1); chk("R2 rise rx", rx_cnt, 1);
    tick(); waitn(1);
    chk("R2 low again", sclk_out, 0);
    tx_cnt = 0; rx_cnt = 0;
    xfer_en = 1'b0; waitn(2);
    chk("R3 forced high", sclk_out, 1);
    tick(); tick(); waitn(2);
    chk("R3 ticks ignored", sclk_out, 1);
    chk("R3 no strobes", tx_cnt + rx_cnt, 0);

    // period limits
    clk_dir = 1'b1; dbuf_en = 1'b1; err_clr = 1'b1; waitn(1); err_clr = 1'b0; waitn(30);
    train(7, 3); waitn(6);
    chk("R8 period 7", clk_err, 0);
    waitn(30); train(6, 3); waitn(6);
    chk("R8 period 6", clk_err, 1);
    waitn(20);
    chk("R10 sticky", clk_err, 1);
    err_clr = 1'b1; waitn(1); err_clr = 1'b0;
    chk("R10 cleared", clk_err, 0);
    dbuf_en = 1'b0; waitn(30);
    train(9, 3); waitn(6);
    chk("R9 period 9", clk_err, 0);
    waitn(30); train(8, 3); waitn(6);
    chk("R9 period 8", clk_err, 1);
    waitn(5);
    chk("R11 dual", dual_cnt, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule